// File: doc/BRIEF.md
# Receiver Start-Up Acquisition Sequencer

This block orders the start-up of a receiver that recovers its clock from the data, without a reference clock. It runs three steps in a fixed order. First the frequency loop is steered onto the shared loop filter while the linear equalizer is pinned at full boost, so that intersymbol interference does not upset frequency pull-in. After frequency lock the filter is handed to the phase loop, and the equalizer is released and told to begin adapting from its lowest gain. When the equalizer reports that adaptation has finished, the sequencer settles in phase tracking and stays there until reset.

The lock and adaptation-finished flags come from other clock domains. Each passes through a two-flop synchronizer before the state machine uses it. A cycle counter guards the frequency step and the adaptation step. If the expected flag does not arrive in time, the machine spends one cycle with both loop switches open and then starts frequency acquisition again. All pins are plain control and status levels. The block has no data stream, so there is no valid/ready handshake.

Top module: `rx_acq_seq`

## Requirements
- R1: While reset is held and in the first cycle after release, phase_code_o is 1 (frequency step), freq_loop_en_o is 1, phase_loop_en_o is 0, eq_force_max_o is 1 and eq_start_o is 0.
- R2: freq_loop_en_o and phase_loop_en_o are never 1 in the same cycle.
- R3: freq_lock_i is synchronized through two flops. A rise that is present before clock edge k moves the machine to the adaptation step (phase_code_o = 2) at edge k+2 and not earlier. In that step freq_loop_en_o is 0, phase_loop_en_o is 1 and eq_force_max_o is 0.
- R4: eq_start_o is 1 for exactly one cycle, the first cycle of the adaptation step, and only when that step is entered from the frequency step.
- R5: eq_done_i is synchronized through two flops. In the adaptation step it moves the machine to tracking (phase_code_o = 3) two edges after it is sampled. In tracking, phase_loop_en_o is 1, and freq_loop_en_o and eq_force_max_o are 0.
- R6: Tracking is final. Changes on freq_lock_i or eq_done_i leave every output unchanged until reset.
- R7: If no lock arrives, the frequency step lasts FREQ_TIMEOUT cycles. It is followed by one retry cycle (phase_code_o = 0, both switches 0, eq_force_max_o = 1), and then the frequency step starts again.
- R8: If no done arrives, the adaptation step lasts EQ_TIMEOUT cycles. It is followed by one retry cycle and then the frequency step, with eq_force_max_o back at 1.
- R9: eq_done_i has no effect during the frequency step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_lock_i | input | 1 | Frequency-lock flag, asynchronous |
| eq_done_i | input | 1 | Equalizer adaptation-finished flag, asynchronous |
| freq_loop_en_o | output | 1 | Closes the frequency-loop switch onto the loop filter |
| phase_loop_en_o | output | 1 | Closes the phase-loop switch onto the loop filter |
| eq_force_max_o | output | 1 | Holds equalizer gain at maximum boost |
| eq_start_o | output | 1 | One-cycle pulse: preset gain to minimum and begin adapting |
| phase_code_o | output | 2 | 0 retry, 1 frequency, 2 adaptation, 3 tracking |

## Verification
The bench measures the lock-to-handover delay edge by edge. A design that skipped or added a synchronizer flop would change step one cycle early or late. It checks the exact length of both timeout windows and the single retry cycle; an off-by-one counter compare moves the retry by one cycle, and a missing retry never opens both switches. It also checks that the start pulse drops after one cycle, that a done flag present during frequency acquisition is ignored, and that tracking holds while both flags toggle. A design that ignored these rules would leave the pulse high, jump ahead to tracking, or fall back out of tracking.

// File: rtl/rx_acq_pkg.sv
package rx_acq_pkg;
  typedef enum logic [1:0] {
    ST_RETRY = 2'd0,
    ST_FREQ  = 2'd1,
    ST_ADAPT = 2'd2,
    ST_TRACK = 2'd3
  } acq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rx_acq_sync.sv
module rx_acq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/rx_acq_timer.sv
module rx_acq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear_i || !run_i) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == last_i);
endmodule

// File: rtl/rx_acq_fsm.sv
module rx_acq_fsm
  import rx_acq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_i,
  input  logic       done_i,
  input  logic       expired_i,
  output acq_state_e state_o,
  output logic       leaving_o,
  output logic       freq_loop_en_o,
  output logic       phase_loop_en_o,
  output logic       eq_force_max_o,
  output logic       eq_start_o
);
  acq_state_e state_q, state_d;
  logic       start_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FREQ: begin
        if (lock_i)         state_d = ST_ADAPT;
        else if (expired_i) state_d = ST_RETRY;
      end
      ST_ADAPT: begin
        if (done_i)         state_d = ST_TRACK;
        else if (expired_i) state_d = ST_RETRY;
      end
      ST_RETRY: state_d = ST_FREQ;
      default:  state_d = ST_TRACK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FREQ;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= (state_q == ST_FREQ) && (state_d == ST_ADAPT);
    end
  end

  always_comb begin
    freq_loop_en_o  = 1'b0;
    phase_loop_en_o = 1'b0;
    eq_force_max_o  = 1'b0;
    case (state_q)
      ST_FREQ:  begin freq_loop_en_o = 1'b1; eq_force_max_o = 1'b1; end
      ST_RETRY: eq_force_max_o = 1'b1;
      default:  phase_loop_en_o = 1'b1;
    endcase
  end

  assign state_o    = state_q;
  assign leaving_o  = (state_d != state_q);
  assign eq_start_o = start_q;
endmodule

// File: rtl/rx_acq_seq.sv
module rx_acq_seq
  import rx_acq_pkg::*;
#(
  parameter int unsigned FREQ_TIMEOUT = 4096,
  parameter int unsigned EQ_TIMEOUT   = 2048,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freq_lock_i,
  input  logic       eq_done_i,
  output logic       freq_loop_en_o,
  output logic       phase_loop_en_o,
  output logic       eq_force_max_o,
  output logic       eq_start_o,
  output logic [1:0] phase_code_o
);
  localparam int unsigned MAX_T = max_u(FREQ_TIMEOUT, EQ_TIMEOUT);
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] FREQ_LAST = CNT_W'(FREQ_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] EQ_LAST   = CNT_W'(EQ_TIMEOUT - 1);

  logic [1:0]       flags_s;
  acq_state_e       state;
  logic             leaving, expired;
  logic [CNT_W-1:0] last;

  rx_acq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({eq_done_i, freq_lock_i}),
    .sync_o(flags_s)
  );

  assign last = (state == ST_FREQ) ? FREQ_LAST : EQ_LAST;

  rx_acq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run_i((state == ST_FREQ) || (state == ST_ADAPT)),
    .clear_i(leaving),
    .last_i(last),
    .expired_o(expired)
  );

  rx_acq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .lock_i(flags_s[0]),
    .done_i(flags_s[1]),
    .expired_i(expired),
    .state_o(state),
    .leaving_o(leaving),
    .freq_loop_en_o(freq_loop_en_o),
    .phase_loop_en_o(phase_loop_en_o),
    .eq_force_max_o(eq_force_max_o),
    .eq_start_o(eq_start_o)
  );

  assign phase_code_o = state;
endmodule

// File: rtl/rx_acq_seq_chk.sv
module rx_acq_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       freq_loop_en_o,
  input logic       phase_loop_en_o,
  input logic       eq_force_max_o,
  input logic       eq_start_o,
  input logic [1:0] phase_code_o
);
  AST_SWITCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(freq_loop_en_o && phase_loop_en_o)); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eq_start_o |=> !eq_start_o); // R4
  AST_START_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    eq_start_o |-> (phase_code_o == 2'd2) && ($past(phase_code_o) == 2'd1)); // R4
  AST_ADAPT_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code_o == 2'd2) |-> phase_loop_en_o && !freq_loop_en_o && !eq_force_max_o); // R3
  AST_FREQ_MAX_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code_o == 2'd1) |-> eq_force_max_o && freq_loop_en_o); // R1
  AST_RETRY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code_o == 2'd0) |-> !freq_loop_en_o && !phase_loop_en_o && eq_force_max_o); // R7
  AST_RETRY_TO_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code_o == 2'd0) |=> (phase_code_o == 2'd1)); // R8
  AST_TRACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code_o == 2'd3) |=> (phase_code_o == 2'd3) && $stable(phase_loop_en_o)); // R6
endmodule

bind rx_acq_seq rx_acq_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .freq_loop_en_o(freq_loop_en_o), .phase_loop_en_o(phase_loop_en_o),
  .eq_force_max_o(eq_force_max_o), .eq_start_o(eq_start_o),
  .phase_code_o(phase_code_o)
);

// File: tb/sim_rx_acq_seq.sv
module sim_rx_acq_seq;
  localparam int F_TO = 40;
  localparam int E_TO = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 1'b0;
  logic done = 1'b0;
  logic f_en, p_en, fmax, start;
  logic [1:0] code;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rx_acq_seq #(.FREQ_TIMEOUT(F_TO), .EQ_TIMEOUT(E_TO)) u0 (
    .clk(clk), .rst_n(rst_n), .freq_lock_i(lock), .eq_done_i(done),
    .freq_loop_en_o(f_en), .phase_loop_en_o(p_en), .eq_force_max_o(fmax),
    .eq_start_o(start), .phase_code_o(code)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected vector packed as {code, f_en, p_en, fmax, start}
  task automatic expect_out(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {code, f_en, p_en, fmax, start};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got code/f/p/max/start=%b expected %b at %0t", req, act, exp, $time);
    end
    n_chk++;
    if (f_en && p_en) begin
      n_fail++;
      $display("FAIL R2: both switches closed, got 11 expected not 11 at %0t", $time);
    end
  endtask

  localparam logic [5:0] O_FREQ  = {2'd1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [5:0] O_RETRY = {2'd0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [5:0] O_ADPS  = {2'd2, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [5:0] O_ADAPT = {2'd2, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [5:0] O_TRACK = {2'd3, 1'b0, 1'b1, 1'b0, 1'b0};

  task automatic do_reset();
    rst_n = 1'b0; lock = 1'b0; done = 1'b0;
    step(2);
    expect_out("R1 in reset", O_FREQ);
    rst_n = 1'b1;
    expect_out("R1 after release", O_FREQ);
  endtask

  task automatic t_full_sequence();
    do_reset();
    step(5);
    lock = 1'b1;
    step(2);
    expect_out("R3 before sync latency", O_FREQ);
    step(1);
    expect_out("R3 R4 adapt entry with pulse", O_ADPS);
    step(1);
    expect_out("R4 pulse gone", O_ADAPT);
    step(4);
    expect_out("R4 adapt steady", O_ADAPT);
    done = 1'b1;
    step(2);
    expect_out("R5 before sync latency", O_ADAPT);
    step(1);
    expect_out("R5 tracking", O_TRACK);
  endtask

  task automatic t_track_sticky();
    lock = 1'b0; done = 1'b0;
    step(10);
    expect_out("R6 flags dropped", O_TRACK);
    lock = 1'b1;
    step(6);
    expect_out("R6 lock re-raised", O_TRACK);
    done = 1'b1; lock = 1'b0;
    step(6);
    expect_out("R6 done toggled", O_TRACK);
  endtask

  task automatic t_freq_timeout();
    do_reset();
    step(F_TO - 1);
    expect_out("R7 last freq cycle", O_FREQ);
    step(1);
    expect_out("R7 retry cycle", O_RETRY);
    step(1);
    expect_out("R7 freq restarted", O_FREQ);
    step(F_TO - 1);
    expect_out("R7 second window", O_FREQ);
    step(1);
    expect_out("R7 second retry", O_RETRY);
  endtask

  task automatic t_adapt_timeout();
    do_reset();
    lock = 1'b1;
    step(3);
    expect_out("R8 adapt entry", O_ADPS);
    step(E_TO - 1);
    expect_out("R8 last adapt cycle", O_ADAPT);
    step(1);
    expect_out("R8 retry cycle", O_RETRY);
    step(1);
    expect_out("R8 back to freq", O_FREQ);
    lock = 1'b0;
  endtask

  task automatic t_done_in_freq();
    do_reset();
    done = 1'b1;
    step(F_TO - 5);
    expect_out("R9 done ignored in freq", O_FREQ);
    lock = 1'b1;
    step(3);
    expect_out("R9 R3 lock still honoured", O_ADPS);
    step(3);
    expect_out("R5 stale done takes adapt to track", O_TRACK);
  endtask

  initial begin
    step(1);
    t_full_sequence();
    t_track_sticky();
    t_freq_timeout();
    t_adapt_timeout();
    t_done_in_freq();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule